// File: doc/BRIEF.md
# Sleep Entry and Exit Sequencer

This block runs the guarded walk into and out of a low-power sleep state for a synchronous memory macro. A level sleep request is sampled on every rising clock edge. Once the request is seen, the sequencer keeps accepting normal inputs through a short guard window, then shuts the input path, flags that low current has been reached and forces the data outputs to high-Z. When the request is dropped, the sleep flag clears at once. The input path stays shut and the outputs stay high-Z for a second guard window, after which normal sampling resumes.

The guard length is the parameter `GUARD`, default 2 clock edges, and it applies to both entry and exit. A request shorter than the entry window still finishes entry before the exit walk begins. An exit that has started always runs to completion. The surrounding logic may issue only deselects or reads during the guard windows, and it treats every input except the sleep request as don't-care while the block is asleep.

Top module: `snooze_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle awake, `in_accept` is 1, `sleep_on` is 0 and `dq_hiz` is 0.
- R2: When `sleep_req` is first sampled high at edge k, the outputs are unchanged after edge k. After edge k+GUARD-1 (k+1 at the default), `in_accept` is 0, `sleep_on` is 1 and `dq_hiz` is 1.
- R3: While `sleep_req` stays high, the asleep outputs (`in_accept` 0, `sleep_on` 1, `dq_hiz` 1) hold for any number of cycles.
- R4: When an asleep sequencer samples `sleep_req` low at edge j, `sleep_on` is 0 right after edge j, with no extra delay. `in_accept` stays 0 and `dq_hiz` stays 1 until edge j+GUARD-1, after which they return to 1 and 0.
- R5: A `sleep_req` pulse that lasts one clock still completes entry. `sleep_on` is then 1 for exactly one cycle, followed by the exit walk of R4.
- R6: Once the exit walk has begun, it completes even if `sleep_req` is raised again. A request still high after the return to awake starts a new entry on the following edge.
- R7: During the entry guard window `in_accept` stays 1 and `dq_hiz` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Level sleep request, sampled each rising edge |
| in_accept | output | 1 | 1 while the macro may sample its normal inputs |
| sleep_on | output | 1 | 1 while the low-current state is reached |
| dq_hiz | output | 1 | 1 forces the data outputs to high-Z |

## Verification
All outputs are decoded from registered state. A request level sampled at one edge therefore shows up on the outputs right after that edge, and the rest of a guard window shows up after each later edge. The driver applies the request on the falling edge and queues the output triple expected after the next rising edge. The monitor pops and compares that triple 2 ns after the rising edge, so every check lands in the cycle its requirement names. The sequences used are a long sleep, a single-cycle pulse, and a request raised again during exit.

// File: rtl/snz_pkg.sv
package snz_pkg;

    typedef enum logic [1:0] {
        SNZ_AWAKE    = 2'd0,
        SNZ_ENTERING = 2'd1,
        SNZ_ASLEEP   = 2'd2,
        SNZ_EXITING  = 2'd3
    } snz_state_e;

    typedef struct packed {
        snz_state_e state;
    } snz_ctl_t;

endpackage

// File: rtl/snz_guard_cnt.sv
module snz_guard_cnt #(
    parameter int GUARD = 2,
    localparam int CW = (GUARD < 2) ? 1 : $clog2(GUARD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic last
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    assign last = (c_q.cnt == CW'(GUARD - 1));

    always_comb begin
        c_d = c_q;
        if (start) begin
            c_d.cnt = CW'(1);
        end else if (run) begin
            if (!last) c_d.cnt = c_q.cnt + CW'(1);
        end else begin
            c_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= CW'(GUARD - 1)); // R2

endmodule

// File: rtl/snz_out_decode.sv
module snz_out_decode
    import snz_pkg::*;
(
    input  snz_state_e state,
    output logic       in_accept,
    output logic       sleep_on,
    output logic       dq_hiz
);

    always_comb begin
        in_accept = 1'b0;
        sleep_on  = 1'b0;
        dq_hiz    = 1'b0;
        unique case (state)
            SNZ_AWAKE:    in_accept = 1'b1;
            SNZ_ENTERING: in_accept = 1'b1;
            SNZ_ASLEEP: begin
                sleep_on = 1'b1;
                dq_hiz   = 1'b1;
            end
            SNZ_EXITING:  dq_hiz = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/snooze_seq.sv
module snooze_seq
    import snz_pkg::*;
#(
    parameter int GUARD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic in_accept,
    output logic sleep_on,
    output logic dq_hiz
);

    snz_ctl_t ctl_d, ctl_q;
    logic     cnt_start;
    logic     cnt_run;
    logic     cnt_last;

    snz_guard_cnt #(.GUARD(GUARD)) i_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cnt_start),
        .run   (cnt_run),
        .last  (cnt_last)
    );

    always_comb begin
        ctl_d     = ctl_q;
        cnt_start = 1'b0;
        cnt_run   = 1'b0;
        unique case (ctl_q.state)
            SNZ_AWAKE: begin
                if (sleep_req) begin
                    if (GUARD < 2) begin
                        ctl_d.state = SNZ_ASLEEP;
                    end else begin
                        ctl_d.state = SNZ_ENTERING;
                        cnt_start   = 1'b1;
                    end
                end
            end
            SNZ_ENTERING: begin
                cnt_run = 1'b1;
                if (cnt_last) ctl_d.state = SNZ_ASLEEP;
            end
            SNZ_ASLEEP: begin
                if (!sleep_req) begin
                    if (GUARD < 2) begin
                        ctl_d.state = SNZ_AWAKE;
                    end else begin
                        ctl_d.state = SNZ_EXITING;
                        cnt_start   = 1'b1;
                    end
                end
            end
            SNZ_EXITING: begin
                cnt_run = 1'b1;
                if (cnt_last) ctl_d.state = SNZ_AWAKE;
            end
            default: ctl_d.state = SNZ_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: SNZ_AWAKE};
        else        ctl_q <= ctl_d;
    end

    snz_out_decode i_dec (
        .state     (ctl_q.state),
        .in_accept (in_accept),
        .sleep_on  (sleep_on),
        .dq_hiz    (dq_hiz)
    );

    AST_SLEEP_SHUTS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_on |-> (!in_accept && dq_hiz)); // R3

    AST_EXIT_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_on) |-> !$past(sleep_req)); // R4

    AST_REOPEN_AFTER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_accept) |-> $past(dq_hiz && !sleep_on)); // R4

    AST_ENTRY_FROM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_on) |-> $past(in_accept || GUARD < 2)); // R2

    AST_ENTRY_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == SNZ_ENTERING) |=> (ctl_q.state != SNZ_AWAKE)); // R5

    AST_EXIT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == SNZ_EXITING) |=> (ctl_q.state != SNZ_ASLEEP)); // R6

    generate
        if (GUARD > 1) begin : g_guard_chk
            AST_ENTRY_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
                (ctl_q.state == SNZ_AWAKE && sleep_req) |=> (in_accept && !dq_hiz)); // R7
        end
    endgenerate

endmodule

// File: tb/test_snooze_seq.sv
module test_snooze_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic in_accept, sleep_on, dq_hiz;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    snooze_seq #(.GUARD(2)) i_snooze_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .in_accept (in_accept),
        .sleep_on  (sleep_on),
        .dq_hiz    (dq_hiz)
    );

    task automatic check(input logic [2:0] exp, input string tag);
        logic [2:0] act;
        act = {in_accept, sleep_on, dq_hiz};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {accept,sleep,hiz} actual %b expected %b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic req, input logic acc, input logic slp,
                        input logic hz, input string tag);
        item_t it;
        @(negedge clk);
        sleep_req = req;
        it.exp = {acc, slp, hz};
        it.tag = tag;
        sb.push_back(it);
    endtask

    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.exp, it.tag);
        end
    end

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(3'b100, "R1 reset");
        rst_n = 1'b1;
        step(0, 1, 0, 0, "R1 idle");

        // long sleep: R7 guard, R2 entry, R3 hold, R4 exit
        step(1, 1, 0, 0, "R7 entry guard");
        step(1, 0, 1, 1, "R2 asleep");
        for (int i = 0; i < 6; i++) step(1, 0, 1, 1, "R3 hold");
        step(0, 0, 0, 1, "R4 exit guard");
        step(0, 1, 0, 0, "R4 reopened");
        step(0, 1, 0, 0, "R1 idle");

        // single-cycle pulse
        step(1, 1, 0, 0, "R5 pulse guard");
        step(0, 0, 1, 1, "R5 asleep one cycle");
        step(0, 0, 0, 1, "R5 exit guard");
        step(0, 1, 0, 0, "R5 reopened");

        // request raised during exit
        step(1, 1, 0, 0, "R2 guard");
        step(1, 0, 1, 1, "R2 asleep");
        step(0, 0, 0, 1, "R4 exit guard");
        step(1, 1, 0, 0, "R6 exit completes");
        step(1, 1, 0, 0, "R6 new entry");
        step(1, 0, 1, 1, "R6 asleep again");
        step(0, 0, 0, 1, "R4 exit guard");
        step(0, 1, 0, 0, "R4 reopened");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule